// File: doc/BRIEF.md
# Parallel Bit Deposit Unit

This unit scatters the low-order bits of a source word into the bit positions chosen by a mask word. It walks the mask from bit 0 upward. Each set mask bit receives the next source bit that has not yet been used, starting at source bit 0. Every result bit whose mask bit is clear is zero. The operation sets no status flags, so the unit has no flag outputs.

The unit works on either 32 or 64 bits. A 64-bit operation needs two things: the core must be in its wide mode, and the width bit of the encoding must be set. In every other case the operation is 32 bits wide. The unit also flags an encoding as illegal when its vector-length bit is set, or when the core runs in a legacy real or virtual-8086 mode.

A caller presents the operands together with `valid_i`. One clock later the unit returns the result with `valid_o`. When `illegal_o` is high the result is zero, and the caller discards it.

Top module: `bit_deposit_unit`

## Requirements
- R1: For each result position m, taken in ascending order, a set mask bit m places the next unused source bit at position m, starting with source bit 0. For example, mask 0xAC (bits 2, 3, 5 and 7 set) with source 0xF gives 0xAC, and with source 0x5 gives 0x24.
- R2: Every result bit whose mask bit is 0 is 0.
- R3: When `wide_mode_i` is 0, the operation is 32 bits wide whatever the value of `width_bit_i`.
- R4: When `wide_mode_i` is 1, the operation is 64 bits wide only if `width_bit_i` is 1. With `width_bit_i` at 0 it is 32 bits wide.
- R5: In a 32-bit operation, result bits 63..32 are zero, and only bits 31..0 of the source and of the mask are used.
- R6: A `vec_len_i` of 1 makes the operation illegal and raises `illegal_o`.
- R7: A `legacy_mode_i` of 1 makes the operation illegal and raises `illegal_o`.
- R8: An illegal operation returns a zero result, and `valid_o` still pulses for it.
- R9: `valid_o` is high exactly one cycle after `valid_i`. `result_o` and `illegal_o` change only one cycle after a cycle with `valid_i` high, and otherwise hold.
- R10: An all-zero mask gives zero. An all-ones mask returns the source unchanged, over the operation width.
- R11: While `rst_ni` is low, `valid_o`, `illegal_o` and `result_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operands valid this cycle |
| src_i | input | 64 | Source word whose low bits are deposited |
| mask_i | input | 64 | Mask selecting the destination positions |
| wide_mode_i | input | 1 | Core runs in its 64-bit mode |
| width_bit_i | input | 1 | Encoding requests 64-bit operand size |
| vec_len_i | input | 1 | Vector-length bit of the encoding; must be 0 |
| legacy_mode_i | input | 1 | Core runs in real or virtual-8086 mode |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 64 | Deposited result |
| illegal_o | output | 1 | The operation was illegal; the result is zero |

## Verification
The bench sweeps every 8-bit low mask pattern against varied sources, and a pseudo-random set of full 64-bit masks, comparing each result with a bit-serial reference model. A design whose running count is off by one would shift every deposited bit by one position. A design that leaked unmasked source bits would show ones where the mask is clear.

Directed cases target the size rules: wide mode with the width bit clear, and the width bit set outside wide mode. A design that decoded the size wrongly would let mask bits above bit 31 populate the upper half of the result.

Illegal encodings are sent with all-ones masks, so a missing squash leaves a nonzero result. Idle cycles between operations expose a result register that does not hold its value, or a valid strobe that stays high.

// File: rtl/bdep_pkg.sv
package bdep_pkg;

  typedef enum logic {
    SZ_32 = 1'b0,
    SZ_64 = 1'b1
  } op_size_e;

  typedef struct packed {
    logic     legal;
    op_size_e size;
  } bdep_ctrl_t;

endpackage

// File: rtl/bdep_decode.sv
module bdep_decode
  import bdep_pkg::*;
(
  input  logic       wide_mode_i,
  input  logic       width_bit_i,
  input  logic       vec_len_i,
  input  logic       legacy_mode_i,
  output bdep_ctrl_t ctrl_o
);

  always_comb begin
    ctrl_o.legal = !vec_len_i && !legacy_mode_i;
    // width bit only counts in wide mode
    ctrl_o.size  = (wide_mode_i && width_bit_i) ? SZ_64 : SZ_32;
  end

endmodule

// File: rtl/bdep_prefix_count.sv
module bdep_prefix_count #(
  parameter  int W  = 64,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]         mask_i,
  output logic [W-1:0][IW-1:0] idx_o
);

  logic [IW-1:0] cnt [W];

  assign cnt[0] = '0;

  // cnt[m] = number of set mask bits strictly below m
  for (genvar m = 1; m < W; m++) begin : g_cnt
    assign cnt[m] = cnt[m-1] + IW'(mask_i[m-1]);
  end

  for (genvar m = 0; m < W; m++) begin : g_pack
    assign idx_o[m] = cnt[m];
  end

endmodule

// File: rtl/bdep_scatter.sv
module bdep_scatter #(
  parameter  int W  = 64,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]         src_i,
  input  logic [W-1:0]         mask_i,
  input  logic [W-1:0][IW-1:0] idx_i,
  output logic [W-1:0]         res_o
);

  for (genvar m = 0; m < W; m++) begin : g_xbar
    assign res_o[m] = mask_i[m] & src_i[idx_i[m]];
  end

endmodule

// File: rtl/bit_deposit_unit.sv
module bit_deposit_unit
  import bdep_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [XLEN-1:0] mask_i,
  input  logic            wide_mode_i,
  input  logic            width_bit_i,
  input  logic            vec_len_i,
  input  logic            legacy_mode_i,
  output logic            valid_o,
  output logic [XLEN-1:0] result_o,
  output logic            illegal_o
);

  localparam int HALF = XLEN / 2;
  localparam int IW   = $clog2(XLEN);

  bdep_ctrl_t             ctrl;
  logic [XLEN-1:0]        eff_src;
  logic [XLEN-1:0]        eff_mask;
  logic [XLEN-1:0][IW-1:0] idx;
  logic [XLEN-1:0]        dep;
  logic [XLEN-1:0]        res_d;

  bdep_decode u_decode (
    .wide_mode_i   (wide_mode_i),
    .width_bit_i   (width_bit_i),
    .vec_len_i     (vec_len_i),
    .legacy_mode_i (legacy_mode_i),
    .ctrl_o        (ctrl)
  );

  // narrow ops see only the low half of each operand
  always_comb begin
    if (ctrl.size == SZ_64) begin
      eff_src  = src_i;
      eff_mask = mask_i;
    end else begin
      eff_src  = {{HALF{1'b0}}, src_i[HALF-1:0]};
      eff_mask = {{HALF{1'b0}}, mask_i[HALF-1:0]};
    end
  end

  bdep_prefix_count #(.W(XLEN)) u_count (
    .mask_i (eff_mask),
    .idx_o  (idx)
  );

  bdep_scatter #(.W(XLEN)) u_scatter (
    .src_i  (eff_src),
    .mask_i (eff_mask),
    .idx_i  (idx),
    .res_o  (dep)
  );

  assign res_d = ctrl.legal ? dep : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= res_d;
        illegal_o <= !ctrl.legal;
      end
    end
  end

endmodule

// File: rtl/bdep_checker.sv
module bdep_checker #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [XLEN-1:0] src_i,
  input logic [XLEN-1:0] mask_i,
  input logic            wide_mode_i,
  input logic            width_bit_i,
  input logic            vec_len_i,
  input logic            legacy_mode_i,
  input logic            valid_o,
  input logic [XLEN-1:0] result_o,
  input logic            illegal_o
);

  localparam int HALF = XLEN / 2;

  AST_UNMASKED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((result_o & ~$past(mask_i)) == '0));  // R2

  AST_NARROW_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !(wide_mode_i && width_bit_i)) |=> (result_o[XLEN-1:HALF] == '0));  // R5

  AST_VLEN_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && vec_len_i) |=> illegal_o);  // R6

  AST_LEGACY_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && legacy_mode_i) |=> illegal_o);  // R7

  AST_ILLEGAL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (result_o == '0));  // R8

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);  // R9

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(illegal_o)));  // R9

  AST_ZERO_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mask_i == '0) |=> (result_o == '0));  // R10

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_STATE: assert (!valid_o && !illegal_o && result_o == '0);  // R11
    end
  end

endmodule

bind bit_deposit_unit bdep_checker #(.XLEN(XLEN)) u_bdep_checker (.*);

// File: tb/tb_bit_deposit_unit.sv
module tb_bit_deposit_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 100000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] src_i = '0;
  logic [63:0] mask_i = '0;
  logic        wide_mode_i = 1'b0;
  logic        width_bit_i = 1'b0;
  logic        vec_len_i = 1'b0;
  logic        legacy_mode_i = 1'b0;
  logic        valid_o;
  logic [63:0] result_o;
  logic        illegal_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  bit_deposit_unit dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > WDOG_LIMIT && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=<%0d", cycles, WDOG_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [63:0] next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  // bit-serial reference model
  function automatic logic [63:0] ref_dep(logic [63:0] s, logic [63:0] m, bit is64);
    logic [63:0] d = '0;
    int k = 0;
    int n = is64 ? 64 : 32;
    for (int p = 0; p < n; p++) begin
      if (m[p]) begin
        d[p] = s[k];
        k++;
      end
    end
    return d;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(logic [63:0] s, logic [63:0] m, bit wm, bit wb, bit vl, bit lg,
                        string tag, bit use_exp = 1'b0, logic [63:0] exp_in = '0);
    logic [63:0] exp;
    bit ill;
    @(negedge clk_i);
    valid_i = 1'b1; src_i = s; mask_i = m;
    wide_mode_i = wm; width_bit_i = wb; vec_len_i = vl; legacy_mode_i = lg;
    ill = vl || lg;
    exp = ill ? 64'h0 : ref_dep(s, m, wm && wb);
    if (use_exp) exp = exp_in;
    @(negedge clk_i);
    chk(result_o == exp, tag, result_o, exp);
    chk(valid_o == 1'b1, {tag, " R9 valid"}, 64'(valid_o), 64'h1);
    chk(illegal_o == ill, {tag, " illegal"}, 64'(illegal_o), 64'(ill));
  endtask

  task automatic idle_chk();
    logic [63:0] prev;
    @(negedge clk_i);
    prev = result_o;
    valid_i = 1'b0;
    src_i = ~src_i; mask_i = ~mask_i;
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R9 idle valid", 64'(valid_o), 64'h0);
    chk(result_o == prev, "R9 idle hold", result_o, prev);
  endtask

  initial begin
    valid_i = 1'b1; mask_i = '1; src_i = '1;
    repeat (3) @(negedge clk_i);
    chk(valid_o == 1'b0 && illegal_o == 1'b0 && result_o == '0, "R11 reset",
        {valid_o, illegal_o, result_o[61:0]}, 64'h0);
    valid_i = 1'b0;
    rst_ni = 1'b1;

    // R1 example cases
    run_op(64'hF, 64'hAC, 1, 1, 0, 0, "R1 example all-ones src", 1'b1, 64'hAC);
    run_op(64'h5, 64'hAC, 1, 1, 0, 0, "R1 example 0101 src", 1'b1, 64'h24);

    // R1 R2 exhaustive 8-bit low mask sweep, 32-bit
    for (int m = 0; m < 256; m++) begin
      run_op(next_rand(), 64'(m), 0, 0, 0, 0, "R1 R2 sweep8");
    end

    // R1 R2 random 64-bit
    for (int i = 0; i < 300; i++) begin
      run_op(next_rand(), next_rand(), 1, 1, 0, 0, "R1 R2 rand64");
    end

    // R3: width bit ignored outside wide mode
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 0, 0,
           "R3 narrow with width bit", 1'b1, 64'h0000_0000_FFFF_FFFF);
    // R4: wide mode without width bit stays 32
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0, 0,
           "R4 wide no width bit", 1'b1, 64'h0000_0000_FFFF_FFFF);
    run_op(64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 0, 0,
           "R4 wide 64", 1'b1, 64'h1234_5678_9ABC_DEF0);
    // R5: upper source/mask bits ignored in 32-bit
    run_op(64'hFFFF_FFFF_0000_0003, 64'hFFFF_0000_8000_0001, 0, 0, 0, 0,
           "R5 upper ignored", 1'b1, 64'h0000_0000_8000_0001);
    for (int i = 0; i < 50; i++) begin
      run_op(next_rand(), next_rand(), 1, 0, 0, 0, "R5 rand32");
    end

    // R6 R7 R8 illegal encodings
    run_op('1, '1, 1, 1, 1, 0, "R6 R8 vec len", 1'b1, 64'h0);
    run_op('1, '1, 1, 1, 0, 1, "R7 R8 legacy", 1'b1, 64'h0);
    run_op('1, '1, 0, 0, 1, 1, "R6 R7 both", 1'b1, 64'h0);
    run_op(64'h5, 64'hAC, 1, 1, 0, 0, "R8 legal after illegal", 1'b1, 64'h24);

    // R10 extremes
    run_op(next_rand(), 64'h0, 1, 1, 0, 0, "R10 zero mask", 1'b1, 64'h0);
    run_op(64'hDEAD_BEEF_CAFE_F00D, '1, 1, 1, 0, 0, "R10 ones mask", 1'b1,
           64'hDEAD_BEEF_CAFE_F00D);
    run_op(64'hDEAD_BEEF_CAFE_F00D, '1, 0, 0, 0, 0, "R10 ones mask 32", 1'b1,
           64'h0000_0000_CAFE_F00D);

    // R9 idle behaviour, including after an illegal op
    idle_chk();
    run_op('1, '1, 1, 1, 1, 0, "R8 pre-idle", 1'b1, 64'h0);
    idle_chk();
    chk(illegal_o == 1'b1, "R9 illegal hold", 64'(illegal_o), 64'h1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule